// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. Software writes a byte into a one-entry holding buffer. Whenever the shift stage is free, the byte moves into the shift stage and goes out on the line as a frame. The frame is a start bit, eight data bits, an optional parity bit and one or two stop bits. Because of the holding buffer, software can queue the next byte while the current frame is still going out. Back-to-back frames then leave no idle gap between them.

Two status flags report progress. The buffer-empty flag says the next byte may be written. The transmit-done flag says the line has gone quiet after the last queued frame, which half-duplex drivers use to turn the bus around. Each flag has an interrupt output behind its own enable. The baud tick comes from outside the block. The pad output-enable tells the pad whether the block owns the line. Turning the transmitter off is deferred until everything queued has been sent.

Top module: `dbuf_uart_tx`

## Requirements
- R1: A frame is sent as one low start bit, then data bits 0 to 7 in that order, then an optional parity bit, then one stop bit, or two stop bits when `ctrl_in[3]` is set, all high. The control word layout is: [0] transmit enable, [1] parity enable, [2] odd parity, [3] two stop bits, [4] buffer-empty interrupt enable, [5] done interrupt enable. It is loaded by `ctrl_we`.
- R2: A pulse on `data_we` loads `data_in` into the holding buffer, and `buf_empty` reads 0 in the following cycle.
- R3: `buf_empty` is 1 exactly when no byte waits in the holding buffer. `irq_empty` is the level `buf_empty` AND `ctrl_in[4]`.
- R4: `tx_done` sets in the cycle after the last stop bit of a frame ends, but only if the holding buffer is empty at that moment.
- R5: `tx_done` clears one cycle after a pulse on `done_w1c` or on `irq_done_ack`. A new setting event in the same cycle wins over the clear.
- R6: `irq_done` is the level `tx_done` AND `ctrl_in[5]`.
- R7: With parity enabled, the parity bit sits between data bit 7 and the first stop bit. It makes the count of ones over data plus parity even, or odd when `ctrl_in[2]` is set.
- R8: After transmit enable is cleared, `txd_oe` stays 1 and sending continues until both the shift stage and the holding buffer are empty.
- R9: Once the transmitter is effectively off, `txd_oe` is 0. A byte written while it is off stays in the buffer and is not sent until transmit enable is set again.
- R10: If a byte is waiting when a frame ends, it enters the shift stage on that same edge. Its start bit follows at once, `buf_empty` goes to 1 and `tx_done` stays 0.
- R11: Every bit lasts exactly 16 pulses of `baud_tick`. Without pulses the line holds its current bit.
- R12: While the transmitter is enabled and no frame is in progress, `txd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One pulse per baud sub-interval, 16 per bit |
| data_we | input | 1 | Write strobe for the holding buffer |
| data_in | input | 8 | Byte to queue |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_in | input | 6 | Control word, layout in R1 |
| done_w1c | input | 1 | Pulse clears the done flag |
| irq_done_ack | input | 1 | Done interrupt acknowledge, clears the done flag |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | High while the block drives the line |
| buf_empty | output | 1 | Holding buffer empty flag |
| tx_done | output | 1 | Transmit done flag |
| irq_empty | output | 1 | Buffer-empty interrupt |
| irq_done | output | 1 | Transmit-done interrupt |

## Verification
A stuck buffer-valid bit shows up within one cycle of a data write. Either `buf_empty` fails to fall, or the byte never reaches the line and no start bit appears on the next edge. A wrong bit index or tick count corrupts the captured frame during the same frame, so every frame is decoded at mid-bit and compared as a whole. A fault in the deferred-disable logic appears at `txd_oe` either one cycle after the line goes idle, or by cutting a queued frame short.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W  = 8;
    localparam int CTRL_W  = 6;
    localparam int FRAME_W = DATA_W + 4;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic irq_done_en;
        logic irq_empty_en;
        logic two_stop;
        logic par_odd;
        logic par_en;
        logic tx_en;
    } ctrl_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [LEN_W-1:0]   len;
    } frame_t;

    function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    function automatic frame_t build_frame(input logic [DATA_W-1:0] d, input ctrl_t c);
        frame_t f;
        f.bits            = '1;
        f.bits[0]         = 1'b0;
        f.bits[DATA_W:1]  = d;
        if (c.par_en)
            f.bits[DATA_W+1] = parity_of(d, c.par_odd);
        f.len = LEN_W'(DATA_W + 2) + LEN_W'(c.par_en) + LEN_W'(c.two_stop);
        return f;
    endfunction

endpackage

// File: rtl/uart_tx_holdbuf.sv
module uart_tx_holdbuf
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else if (wr) begin
            valid <= 1'b1;
            data  <= wdata;
        end else if (take) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic baud_tick,
    output logic bit_end
);
    localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICKS_PER_BIT - 1);

    logic [TW-1:0] cnt;

    assign bit_end = run && baud_tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (run && baud_tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  frame_t next_frame,
    input  logic   bit_end,
    output logic   busy,
    output logic   line,
    output logic   frame_end
);
    logic [FRAME_W-1:0] sh;
    logic [LEN_W-1:0]   left;

    assign frame_end = busy && bit_end && (left == LEN_W'(1));
    assign line      = busy ? sh[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sh   <= next_frame.bits;
            left <= next_frame.len;
        end else if (frame_end) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
        end else if (busy && bit_end) begin
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status
    import uart_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  busy,
    input  logic  buf_valid,
    input  logic  frame_end,
    input  logic  take,
    input  logic  done_w1c,
    input  logic  done_ack,
    output logic  eff_en,
    output logic  done,
    output logic  irq_empty,
    output logic  irq_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            eff_en <= 1'b0;
            done   <= 1'b0;
        end else begin
            if (ctrl.tx_en)
                eff_en <= 1'b1;
            else if (!busy && !buf_valid)
                eff_en <= 1'b0;

            if (frame_end && !take)
                done <= 1'b1;
            else if (done_w1c || done_ack)
                done <= 1'b0;
        end
    end

    assign irq_empty = !buf_valid && ctrl.irq_empty_en;
    assign irq_done  = done && ctrl.irq_done_en;
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic              done_w1c,
    input  logic              irq_done_ack,
    output logic              txd,
    output logic              txd_oe,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              irq_empty,
    output logic              irq_done
);
    ctrl_t             ctrl_q;
    logic              buf_valid;
    logic [DATA_W-1:0] buf_data;
    logic              busy;
    logic              bit_end;
    logic              frame_end;
    logic              eff_en;
    logic              take;
    frame_t            nf;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= ctrl_t'(ctrl_in);
    end

    assign take = eff_en && buf_valid && (!busy || frame_end);
    assign nf   = build_frame(buf_data, ctrl_q);

    uart_tx_holdbuf u_buf (
        .clk   (clk),
        .rst   (rst),
        .wr    (data_we),
        .wdata (data_in),
        .take  (take),
        .valid (buf_valid),
        .data  (buf_data)
    );

    uart_tx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
        .clk       (clk),
        .rst       (rst),
        .restart   (take),
        .run       (busy),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    uart_tx_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (take),
        .next_frame (nf),
        .bit_end    (bit_end),
        .busy       (busy),
        .line       (txd),
        .frame_end  (frame_end)
    );

    uart_tx_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .busy      (busy),
        .buf_valid (buf_valid),
        .frame_end (frame_end),
        .take      (take),
        .done_w1c  (done_w1c),
        .done_ack  (irq_done_ack),
        .eff_en    (eff_en),
        .done      (tx_done),
        .irq_empty (irq_empty),
        .irq_done  (irq_done)
    );

    assign txd_oe    = eff_en;
    assign buf_empty = !buf_valid;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
    input logic clk,
    input logic rst,
    input logic data_we,
    input logic done_w1c,
    input logic irq_done_ack,
    input logic buf_empty,
    input logic tx_done,
    input logic irq_empty,
    input logic irq_done,
    input logic txd,
    input logic txd_oe,
    input logic busy,
    input logic frame_end
);
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        data_we |=> !buf_empty); // R2

    AST_EMPTY_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        !buf_empty |-> !irq_empty); // R3

    AST_DONE_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> ($past(frame_end) && $past(buf_empty))); // R4

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ((done_w1c || irq_done_ack) && !frame_end) |=> !tx_done); // R5

    AST_DONE_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> tx_done); // R6

    AST_OE_HOLDS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (txd_oe && (busy || !buf_empty)) |=> txd_oe); // R8

    AST_RELOAD_START: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !buf_empty) |=> (busy && !txd)); // R10

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd); // R12
endmodule

bind dbuf_uart_tx uart_tx_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .data_we      (data_we),
    .done_w1c     (done_w1c),
    .irq_done_ack (irq_done_ack),
    .buf_empty    (buf_empty),
    .tx_done      (tx_done),
    .irq_empty    (irq_empty),
    .irq_done     (irq_done),
    .txd          (txd),
    .txd_oe       (txd_oe),
    .busy         (busy),
    .frame_end    (frame_end)
);

// File: tb/dbuf_uart_tx_bench.sv
module dbuf_uart_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] data_in = '0;
    logic       ctrl_we = 1'b0;
    logic [5:0] ctrl_in = '0;
    logic       done_w1c = 1'b0;
    logic       irq_done_ack = 1'b0;
    logic       txd, txd_oe, buf_empty, tx_done, irq_empty, irq_done;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dbuf_uart_tx u_dbuf_uart_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick),
        .data_we(data_we), .data_in(data_in),
        .ctrl_we(ctrl_we), .ctrl_in(ctrl_in),
        .done_w1c(done_w1c), .irq_done_ack(irq_done_ack),
        .txd(txd), .txd_oe(txd_oe), .buf_empty(buf_empty),
        .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [5:0] v);
        ctrl_in = v; ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d);
        data_in = d; data_we = 1'b1;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic clear_done;
        done_w1c = 1'b1;
        @(negedge clk);
        done_w1c = 1'b0;
    endtask

    task automatic pulse_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input bit pe, input bit po, input bit ts, output int n);
        logic [11:0] f;
        int ones;
        f = 12'hFFF;
        f[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < 8; i++) begin
            f[1+i] = d[i];
            ones += int'(d[i]);
        end
        if (pe) f[9] = ((ones % 2) == 1) ^ po;
        n = 10 + int'(pe) + int'(ts);
        return f;
    endfunction

    // Drives 16 ticks per bit from the start bit on, samples mid-bit.
    task automatic run_frame(input logic [11:0] ef, input int n, input int gap, input string req);
        logic [11:0] got;
        logic [11:0] mask;
        got = 12'hFFF;
        for (int b = 0; b < n; b++) begin
            for (int t = 0; t < 16; t++) begin
                baud_tick = 1'b1;
                @(negedge clk);
                baud_tick = 1'b0;
                if (t == 7) got[b] = txd;
                repeat (gap) @(negedge clk);
            end
        end
        mask = 12'((1 << n) - 1);
        chk((got & mask) == (ef & mask), req, 32'(got & mask), 32'(ef & mask));
    endtask

    task automatic send_one(input logic [7:0] d, input bit pe, input bit po, input bit ts, input int gap);
        logic [11:0] ef;
        int n;
        ef = exp_frame(d, pe, po, ts, n);
        wr_data(d);
        chk(buf_empty == 1'b0, "R2 buf_empty after write", 32'(buf_empty), 0);
        chk(irq_empty == 1'b0, "R3 irq_empty with byte waiting", 32'(irq_empty), 0);
        @(negedge clk);
        chk(txd == 1'b0 && buf_empty == 1'b1, "R1 start bit / R3 buffer drained", 32'({txd, buf_empty}), 32'h1);
        run_frame(ef, n, gap, "R1/R7 frame");
        chk(tx_done == 1'b1, "R4 done after frame", 32'(tx_done), 1);
        chk(irq_done == 1'b1, "R6 irq_done", 32'(irq_done), 1);
        chk(txd == 1'b1, "R12 idle high", 32'(txd), 1);
        clear_done;
        chk(tx_done == 1'b0, "R5 write-one clear", 32'(tx_done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        logic [11:0] ef;
        int n;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd_oe == 1'b0, "R9 reset oe", 32'(txd_oe), 0);
        chk(buf_empty == 1'b1, "R3 reset buf_empty", 32'(buf_empty), 1);
        chk(tx_done == 1'b0 && irq_done == 1'b0 && irq_empty == 1'b0, "R6 reset flags", 32'({tx_done, irq_done, irq_empty}), 0);
        chk(txd == 1'b1, "R12 reset line", 32'(txd), 1);

        wr_ctrl(6'b110001);
        @(negedge clk);
        chk(txd_oe == 1'b1 && txd == 1'b1, "R12 enabled idle", 32'({txd_oe, txd}), 3);
        chk(irq_empty == 1'b1, "R3 irq_empty level", 32'(irq_empty), 1);

        // Sweep all frame formats and several bytes, varying tick spacing.
        for (int cfg = 0; cfg < 8; cfg++) begin
            wr_ctrl({2'b11, cfg[2], cfg[1], cfg[0], 1'b1});
            for (int k = 0; k < 4; k++)
                send_one(pats[k], cfg[0], cfg[1], cfg[2], cfg % 3);
        end

        // Every byte value with odd parity.
        wr_ctrl(6'b110111);
        for (int d = 0; d < 256; d++)
            send_one(8'(d), 1'b1, 1'b1, 1'b0, 0);

        // R11: the line holds without ticks, bit length is 16 ticks.
        wr_ctrl(6'b110001);
        wr_data(8'h5B);
        @(negedge clk);
        repeat (40) @(negedge clk);
        chk(txd == 1'b0, "R11 hold without ticks", 32'(txd), 0);
        pulse_ticks(15, 0);
        chk(txd == 1'b0, "R11 start after 15 ticks", 32'(txd), 0);
        pulse_ticks(1, 0);
        chk(txd == 1'b1, "R11 bit0 after 16 ticks", 32'(txd), 1);
        pulse_ticks(16 * 9, 0);
        chk(tx_done == 1'b1, "R4 done after held frame", 32'(tx_done), 1);
        clear_done;

        // R10: back-to-back frames, next byte loads on the final edge.
        wr_data(8'hC3);
        @(negedge clk);
        wr_data(8'h17);
        chk(buf_empty == 1'b0, "R10 second byte queued", 32'(buf_empty), 0);
        ef = exp_frame(8'hC3, 1'b0, 1'b0, 1'b0, n);
        run_frame(ef, n, 0, "R10 first frame");
        chk(txd == 1'b0, "R10 start bit follows at once", 32'(txd), 0);
        chk(buf_empty == 1'b1, "R10 buffer empty after reload", 32'(buf_empty), 1);
        chk(tx_done == 1'b0, "R10 done stays low", 32'(tx_done), 0);
        ef = exp_frame(8'h17, 1'b0, 1'b0, 1'b0, n);
        run_frame(ef, n, 1, "R10 second frame");
        chk(tx_done == 1'b1, "R4 done after second frame", 32'(tx_done), 1);
        irq_done_ack = 1'b1;
        @(negedge clk);
        irq_done_ack = 1'b0;
        chk(tx_done == 1'b0 && irq_done == 1'b0, "R5 acknowledge clears", 32'({tx_done, irq_done}), 0);

        // R8/R9: deferred disable.
        wr_data(8'h81);
        @(negedge clk);
        wr_data(8'h7E);
        wr_ctrl(6'b110000);
        chk(txd_oe == 1'b1, "R8 oe held with data pending", 32'(txd_oe), 1);
        ef = exp_frame(8'h81, 1'b0, 1'b0, 1'b0, n);
        run_frame(ef, n, 0, "R8 first frame after disable");
        chk(txd_oe == 1'b1 && txd == 1'b0, "R8 queued frame still sent", 32'({txd_oe, txd}), 2);
        ef = exp_frame(8'h7E, 1'b0, 1'b0, 1'b0, n);
        run_frame(ef, n, 0, "R8 second frame after disable");
        repeat (2) @(negedge clk);
        chk(txd_oe == 1'b0, "R9 oe released", 32'(txd_oe), 0);
        clear_done;
        wr_data(8'h99);
        pulse_ticks(40, 0);
        chk(buf_empty == 1'b0 && txd_oe == 1'b0, "R9 byte held while off", 32'({buf_empty, txd_oe}), 0);
        wr_ctrl(6'b110001);
        @(negedge clk);
        chk(txd_oe == 1'b1, "R9 re-enable drives line", 32'(txd_oe), 1);
        @(negedge clk);
        chk(txd == 1'b0 && buf_empty == 1'b1, "R9 held byte starts", 32'({txd, buf_empty}), 1);
        ef = exp_frame(8'h99, 1'b0, 1'b0, 1'b0, n);
        run_frame(ef, n, 0, "R9 held frame");

        // Interrupt enables off.
        wr_ctrl(6'b000001);
        chk(tx_done == 1'b1 && irq_done == 1'b0, "R6 irq_done masked", 32'({tx_done, irq_done}), 2);
        chk(buf_empty == 1'b1 && irq_empty == 1'b0, "R3 irq_empty masked", 32'({buf_empty, irq_empty}), 2);
        clear_done;
        chk(tx_done == 1'b0, "R5 clear after mask", 32'(tx_done), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule